// File: doc/BRIEF.md
# Cascadable CAM Slice with Priority Chain

This block is a single slice of a content-addressable memory built to be stacked vertically. Each slice holds a parameterised number of entries, 16 words of 32 bits by default. It joins three ripple chains with its neighbours: match, multiple match and full. Through these chains a stack of slices behaves as one prioritised CAM. The topmost slice has the highest priority. Inside a slice, the lowest-numbered entry wins.

All operations commit on a clock edge at which the cycle strobe `e_stb` is high. The slice holds its match result and its match-valid qualifier in registers. The chain outputs are formed combinationally from that registered state and the chain inputs from the slice above. The chain therefore settles by rippling through the stack after each committing edge.

Writes go to the first slice that still has room. That slice sees an active full-in and is not itself full. A compare latches a fresh match result in every slice. Afterwards only the slice that holds the system's highest-priority match may place its page and entry address and the matched word on the output bus, and only while output enable is active. Every other slice keeps those outputs in high impedance.

Top module: `cam_chain_slice`

## Requirements
- R1: While `rst_n` is low, all entries become invalid and the stored match result and match-valid qualifier clear. After reset, `mf_n`, `mm_n` and `mv_n` follow the chain inputs as if there were no local hit, `ff_n` is high and `drv_en` is low.
- R2: A committed write (`op` = 1) stores `key` into the lowest-numbered invalid entry, but only when `fi_n` is low and the slice is not full. Otherwise the write leaves the slice unchanged.
- R3: `ff_n` is low exactly when `fi_n` is low and every entry of the slice is valid.
- R4: A committed compare (`op` = 2) latches which valid entries equal `key`, and the lowest-numbered hit has priority. `mf_n` is low when `mi_n` is low or the latched result has a hit. Writes do not alter the latched result.
- R5: `mm_n` is low when `mmi_n` is low, when the latched result holds two or more hits, or when it holds a hit while `mi_n` is low.
- R6: `mv_n` is low when the latched result has a hit and `vp_hit` was high at the committing compare edge.
- R7: `drv_en` is high exactly when `oe_n` is low, `mi_n` is high and the slice has a hit. While it is high, `m_addr` = {`page_id`, index of the lowest-numbered hit} and `m_data` is that entry's word. Both buses are high impedance otherwise.
- R8: A committed clear (`op` = 3) invalidates every entry and drops the latched match result and qualifier.
- R9: With `e_stb` low, no operation takes effect, whatever `op`, `key` and `vp_hit` carry. Operation code 0 is a no-op even when strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e_stb | input | 1 | Cycle strobe; the operation commits at this edge |
| op | input | 2 | 0 none, 1 write, 2 compare, 3 clear |
| key | input | WIDTH | Write data or compare key |
| vp_hit | input | 1 | Side-table hit qualifier, sampled at compare |
| oe_n | input | 1 | Active-low output enable for the result buses |
| page_id | input | PAGE_W | Strapped position of this slice in the stack |
| mi_n | input | 1 | Match-in from the slice above, active low |
| fi_n | input | 1 | Full-in from the slice above, active low |
| mmi_n | input | 1 | Multiple-match-in from the slice above, active low |
| mf_n | output | 1 | Match-out to the slice below, active low |
| ff_n | output | 1 | Full-out to the slice below, active low |
| mm_n | output | 1 | Multiple-match-out to the slice below, active low |
| mv_n | output | 1 | Match-valid, active low |
| drv_en | output | 1 | High while this slice drives the result buses |
| m_addr | output | PAGE_W+log2(ENTRIES) | Page and entry address of the winning hit, tristate |
| m_data | output | WIDTH | Word at the winning entry, tristate |

## Verification
The assertions assume the chain inputs come from a correctly ordered stack: the top slice has `mi_n` and `mmi_n` tied high and `fi_n` tied low, and each lower slice takes its inputs from the outputs of the slice above. They also assume `op` and `e_stb` hold steady around each clock edge. The bench keeps to these rules by building a real two-slice stack with its chain wired slice to slice. It changes the shared operation inputs only on falling edges, and it reads the flags after the chain has settled on the following falling edge.

// File: rtl/cam_chain_pkg.sv
package cam_chain_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_COMPARE = 2'd2,
        OP_CLEAR   = 2'd3
    } cam_op_e;

endpackage

// File: rtl/cam_prio_enc.sv
// Lowest-index-first priority encoder with a "more than one set" detector.
module cam_prio_enc #(
    parameter int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic             multi_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
        any_o   = |vec_i;
        multi_o = (vec_i & (vec_i - N'(1))) != '0;
    end

    // R4: the chosen index is set and nothing below it is set
    always_comb begin
        if (any_o) begin
            p_idx_is_set_r4: assert (vec_i[idx_o]);
            p_idx_lowest_r4: assert ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0);
        end
    end

endmodule

// File: rtl/cam_slice_store.sv
// Entry storage, valid bits and the latched match vector of one slice.
module cam_slice_store
    import cam_chain_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  cam_op_e            op_i,
    input  logic [WIDTH-1:0]   key_i,
    input  logic               wr_allow_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [ENTRIES-1:0] valid_o,
    output logic [ENTRIES-1:0] hits_o,
    output logic               full_o,
    output logic [WIDTH-1:0]   rd_data_o
);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            hits;
        logic [ENTRIES-1:0][WIDTH-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    logic             free_any;
    logic             free_multi;
    logic [IDX_W-1:0] free_idx;

    cam_prio_enc #(.N(ENTRIES)) u_free (
        .vec_i   (~st_q.valid),
        .any_o   (free_any),
        .multi_o (free_multi),
        .idx_o   (free_idx)
    );

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            unique case (op_i)
                OP_WRITE: begin
                    if (wr_allow_i && free_any) begin
                        st_d.valid[free_idx] = 1'b1;
                        st_d.mem[free_idx]   = key_i;
                    end
                end
                OP_COMPARE: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        st_d.hits[i] = st_q.valid[i] && (st_q.mem[i] == key_i);
                    end
                end
                OP_CLEAR: begin
                    st_d.valid = '0;
                    st_d.hits  = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o   = st_q.valid;
    assign hits_o    = st_q.hits;
    assign full_o    = !free_any;
    assign rd_data_o = st_q.mem[rd_idx_i];

    // R4: a latched hit always refers to an entry that is still valid or was just written over
    p_hit_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && op_i == OP_COMPARE) |=> ((hits_o & ~valid_o) == '0));

    // R2: a free slot exists whenever the slice is not full (more than one free is allowed)
    p_free_multi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        free_multi |-> (free_any && !full_o));

endmodule

// File: rtl/cam_chain_slice.sv
// One stackable CAM slice taking part in the match, multiple-match and full chains.
module cam_chain_slice
    import cam_chain_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    parameter int PAGE_W  = 4,
    localparam int LA_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int ADDR_W = PAGE_W + LA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_stb,
    input  logic [1:0]        op,
    input  logic [WIDTH-1:0]  key,
    input  logic              vp_hit,
    input  logic              oe_n,
    input  logic [PAGE_W-1:0] page_id,
    input  logic              mi_n,
    input  logic              fi_n,
    input  logic              mmi_n,
    output logic              mf_n,
    output logic              ff_n,
    output logic              mm_n,
    output logic              mv_n,
    output logic              drv_en,
    output logic [ADDR_W-1:0] m_addr,
    output logic [WIDTH-1:0]  m_data
);

    typedef struct packed {
        logic vp;
    } slice_t;

    slice_t sl_d, sl_q;

    cam_op_e            op_e;
    logic [ENTRIES-1:0] valid_v;
    logic [ENTRIES-1:0] hit_v;
    logic               slice_full;
    logic [WIDTH-1:0]   win_data;
    logic               hit_any;
    logic               hit_multi;
    logic [LA_W-1:0]    hit_idx;

    assign op_e = cam_op_e'(op);

    cam_slice_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (e_stb),
        .op_i       (op_e),
        .key_i      (key),
        .wr_allow_i (!fi_n),
        .rd_idx_i   (hit_idx),
        .valid_o    (valid_v),
        .hits_o     (hit_v),
        .full_o     (slice_full),
        .rd_data_o  (win_data)
    );

    cam_prio_enc #(.N(ENTRIES)) u_hit (
        .vec_i   (hit_v),
        .any_o   (hit_any),
        .multi_o (hit_multi),
        .idx_o   (hit_idx)
    );

    always_comb begin
        sl_d = sl_q;
        if (e_stb) begin
            if (op_e == OP_COMPARE)    sl_d.vp = vp_hit;
            else if (op_e == OP_CLEAR) sl_d.vp = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    // chain outputs, settling combinationally from registered state
    assign mf_n   = mi_n & ~hit_any;
    assign mm_n   = mmi_n & ~(hit_multi | (hit_any & ~mi_n));
    assign mv_n   = ~(hit_any & sl_q.vp);
    assign ff_n   = ~(~fi_n & slice_full);
    assign drv_en = ~oe_n & mi_n & hit_any;

    assign m_addr = drv_en ? {page_id, hit_idx} : {ADDR_W{1'bz}};
    assign m_data = drv_en ? win_data : {WIDTH{1'bz}};

    // R9: without the strobe the match result and contents hold
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !e_stb |=> ($stable(hit_v) && $stable(valid_v)));

    // R4: a write never disturbs the latched match result
    p_write_keeps_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_stb && op_e == OP_WRITE) |=> $stable(hit_v));

    // R2: an accepted write adds exactly one valid entry
    p_write_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (e_stb && op_e == OP_WRITE && !fi_n && !slice_full)
        |=> ($countones(valid_v) == $countones($past(valid_v)) + 1));

    // R2: a refused write leaves the contents untouched
    p_write_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (e_stb && op_e == OP_WRITE && (fi_n || slice_full)) |=> $stable(valid_v));

    // R8: clear empties the slice and drops any hit
    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (e_stb && op_e == OP_CLEAR) |=> (valid_v == '0 && mv_n && ff_n && !drv_en));

    // R7: only the system winner drives, and it reports a match
    p_drive_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!mf_n && mi_n && !oe_n));

    // R5: a local multiple match is also a match
    p_mm_has_mf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mm_n && mmi_n) |-> !mf_n);

    // R6: match-valid only accompanies a match
    p_mv_has_mf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_n |-> !mf_n);

    // R3: a full slice below an empty-ish chain cannot flag full
    p_ff_needs_fi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ff_n |-> !fi_n);

endmodule

// File: tb/cam_chain_slice_tb.sv
module cam_chain_slice_tb;

    localparam int ENTRIES = 4;
    localparam int WIDTH   = 32;
    localparam int PAGE_W  = 4;
    localparam int ADDR_W  = PAGE_W + 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic             rst_n;
    logic             stb;
    logic [1:0]       op;
    logic [WIDTH-1:0] key;
    logic             vp;
    logic             oe_n;

    wire              t_mf, t_ff, t_mm, t_mv, t_en;
    wire              l_mf, l_ff, l_mm, l_mv, l_en;
    wire [ADDR_W-1:0] t_addr, l_addr;
    wire [WIDTH-1:0]  t_data, l_data;

    cam_chain_slice #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .PAGE_W(PAGE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .e_stb(stb), .op(op), .key(key), .vp_hit(vp),
        .oe_n(oe_n), .page_id(4'd0), .mi_n(1'b1), .fi_n(1'b0), .mmi_n(1'b1),
        .mf_n(t_mf), .ff_n(t_ff), .mm_n(t_mm), .mv_n(t_mv), .drv_en(t_en),
        .m_addr(t_addr), .m_data(t_data)
    );

    cam_chain_slice #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .PAGE_W(PAGE_W)) u_low (
        .clk(clk), .rst_n(rst_n), .e_stb(stb), .op(op), .key(key), .vp_hit(vp),
        .oe_n(oe_n), .page_id(4'd1), .mi_n(t_mf), .fi_n(t_ff), .mmi_n(t_mm),
        .mf_n(l_mf), .ff_n(l_ff), .mm_n(l_mm), .mv_n(l_mv), .drv_en(l_en),
        .m_addr(l_addr), .m_data(l_data)
    );

    // fl = {top mf,mm,mv,ff, low mf,mm,mv,ff}
    typedef struct packed {
        logic              stb;
        logic [1:0]        op;
        logic [WIDTH-1:0]  key;
        logic              vp;
        logic              oe_n;
        logic [7:0]        fl;
        logic              ten;
        logic [ADDR_W-1:0] taddr;
        logic              len;
        logic [ADDR_W-1:0] laddr;
        logic [WIDTH-1:0]  data;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd1, 32'h11, 1'b0, 1'b1, 8'hFF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00}, // R2 top e0
        '{1'b1, 2'd1, 32'h22, 1'b0, 1'b1, 8'hFF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00},
        '{1'b1, 2'd1, 32'h11, 1'b0, 1'b1, 8'hFF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00},
        '{1'b1, 2'd1, 32'h33, 1'b0, 1'b1, 8'hEF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00}, // R3 top full
        '{1'b1, 2'd2, 32'h22, 1'b1, 1'b0, 8'h47, 1'b1, 6'h01, 1'b0, 6'h00, 32'h22}, // R4 single hit
        '{1'b1, 2'd1, 32'h11, 1'b0, 1'b0, 8'h47, 1'b1, 6'h01, 1'b0, 6'h00, 32'h22}, // R4 write keeps match
        '{1'b1, 2'd2, 32'h11, 1'b0, 1'b0, 8'h23, 1'b1, 6'h00, 1'b0, 6'h00, 32'h11}, // R5 multi
        '{1'b1, 2'd2, 32'h44, 1'b1, 1'b0, 8'hEF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00},
        '{1'b1, 2'd1, 32'h44, 1'b0, 1'b0, 8'hEF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00},
        '{1'b1, 2'd2, 32'h44, 1'b1, 1'b0, 8'hE5, 1'b0, 6'h00, 1'b1, 6'h05, 32'h44}, // R7 low wins
        '{1'b0, 2'd0, 32'h00, 1'b0, 1'b1, 8'hE5, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00}, // R7 oe off
        '{1'b0, 2'd2, 32'h11, 1'b0, 1'b0, 8'hE5, 1'b0, 6'h00, 1'b1, 6'h05, 32'h44}, // R9 no strobe
        '{1'b1, 2'd1, 32'h55, 1'b0, 1'b0, 8'hE5, 1'b0, 6'h00, 1'b1, 6'h05, 32'h44},
        '{1'b1, 2'd1, 32'h66, 1'b0, 1'b0, 8'hE4, 1'b0, 6'h00, 1'b1, 6'h05, 32'h44}, // R3 low full
        '{1'b1, 2'd1, 32'h77, 1'b0, 1'b0, 8'hE4, 1'b0, 6'h00, 1'b1, 6'h05, 32'h44}, // R2 refused
        '{1'b1, 2'd2, 32'h77, 1'b1, 1'b0, 8'hEE, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00}, // R2 not stored
        '{1'b1, 2'd3, 32'h00, 1'b0, 1'b0, 8'hFF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00}, // R8 clear
        '{1'b1, 2'd2, 32'h11, 1'b1, 1'b0, 8'hFF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00}, // R8 gone
        '{1'b1, 2'd1, 32'h11, 1'b0, 1'b0, 8'hFF, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00},
        '{1'b1, 2'd2, 32'h11, 1'b1, 1'b0, 8'h57, 1'b1, 6'h00, 1'b0, 6'h00, 32'h11}, // R6 mv
        '{1'b1, 2'd2, 32'h11, 1'b1, 1'b1, 8'h57, 1'b0, 6'h00, 1'b0, 6'h00, 32'h00}  // R7 oe gate
    };

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp, input int row);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s row %0d: actual %0h expected %0h", req, what, row, act, exp);
        end
    endtask

    task automatic chk_row(input vec_t v, input int row);
        chk("R4", "top mf", 64'(t_mf), 64'(v.fl[7]), row);
        chk("R5", "top mm", 64'(t_mm), 64'(v.fl[6]), row);
        chk("R6", "top mv", 64'(t_mv), 64'(v.fl[5]), row);
        chk("R3", "top ff", 64'(t_ff), 64'(v.fl[4]), row);
        chk("R4", "low mf", 64'(l_mf), 64'(v.fl[3]), row);
        chk("R5", "low mm", 64'(l_mm), 64'(v.fl[2]), row);
        chk("R6", "low mv", 64'(l_mv), 64'(v.fl[1]), row);
        chk("R3", "low ff", 64'(l_ff), 64'(v.fl[0]), row);
        chk("R7", "top drv", 64'(t_en), 64'(v.ten), row);
        chk("R7", "low drv", 64'(l_en), 64'(v.len), row);
        if (v.ten) begin
            chk("R7", "top addr", 64'(t_addr), 64'(v.taddr), row);
            chk("R7", "top data", 64'(t_data), 64'(v.data), row);
        end
        if (v.len) begin
            chk("R7", "low addr", 64'(l_addr), 64'(v.laddr), row);
            chk("R7", "low data", 64'(l_data), 64'(v.data), row);
        end
    endtask

    task automatic chk_reset_state(input int row);
        // R1: empty stack, no flags, nothing driven
        chk("R1", "top mf", 64'(t_mf), 64'd1, row);
        chk("R1", "top mm", 64'(t_mm), 64'd1, row);
        chk("R1", "top mv", 64'(t_mv), 64'd1, row);
        chk("R1", "top ff", 64'(t_ff), 64'd1, row);
        chk("R1", "low mf", 64'(l_mf), 64'd1, row);
        chk("R1", "low ff", 64'(l_ff), 64'd1, row);
        chk("R1", "top drv", 64'(t_en), 64'd0, row);
        chk("R1", "low drv", 64'(l_en), 64'd0, row);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stb = 1'b0; op = 2'd0; key = '0; vp = 1'b0; oe_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state(-1);

        for (int r = 0; r < NV; r++) begin
            stb  = VECS[r].stb;
            op   = VECS[r].op;
            key  = VECS[r].key;
            vp   = VECS[r].vp;
            oe_n = VECS[r].oe_n;
            @(negedge clk);
            chk_row(VECS[r], r);
        end

        // R9: strobed no-op keeps the winner from the last row
        stb = 1'b1; op = 2'd0; key = 32'h11; vp = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk("R9", "noop keeps drv", 64'(t_en), 64'd1, 100);
        chk("R9", "noop keeps mv", 64'(t_mv), 64'd0, 100);

        // R1: reset in the middle of a loaded stack
        stb = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state(101);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule